// File: doc/BRIEF.md
# Processor Presence Bitmap

This block keeps one bit per processor slot, indexed by processor number, telling firmware which processors are currently present. At reset the whole map is loaded from a parallel boot-presence vector, so processors that exist at power-on are already marked before software can look. After reset, a hotplug controller delivers plug and unplug events. Each event carries a processor number and sets or clears that processor's bit.

Software sees the map as a read-only window of bytes on a single-byte register port. Processor `n` sits in byte `n/8`, bit `n%8`. Writes into the window are accepted on the bus and discarded. Every accepted event also raises a one-cycle request for the hotplug status bit of the general-purpose event block, so that the interrupt logic downstream re-evaluates its line. Event numbers beyond the map are dropped and reported on an error pulse.

Top module: `cpuhp_presence_map`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the map is loaded from `boot_present` (bit n = processor n), and reads issued after reset return those values.
- R2: A read (`rd_en` high) of byte offset k puts bits 8k+7..8k of the map on `rd_data` one cycle later, with bit j of `rd_data` = processor 8k+j. `rd_data` holds its value while `rd_en` is low.
- R3: An accepted event with `evt_plug` = 1 sets the addressed processor's bit and leaves every other bit unchanged.
- R4: An accepted event with `evt_plug` = 0 clears the addressed processor's bit and leaves every other bit unchanged.
- R5: Each accepted event (`evt_valid` high, `evt_id` < 256) makes `gpe_set` equal 8'h04 (status bit 2) for exactly the following cycle. In every other cycle `gpe_set` is zero.
- R6: Writes (`wr_en`, `wr_addr`, `wr_data`) never change the map.
- R7: An event with `evt_id` >= 256 leaves the map unchanged and raises no `gpe_set`. It pulses `evt_err` high for the following cycle. `evt_err` is low otherwise.
- R8: When a read and an event address the same byte in the same cycle, the read returns the value from before the event, and a later read returns the updated value.
- R9: After reset, `rd_data`, `gpe_set` and `evt_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the boot map |
| boot_present | input | 256 | Processors present at power-on, bit n = processor n |
| evt_valid | input | 1 | Hotplug event strobe |
| evt_plug | input | 1 | 1 = plug, 0 = unplug |
| evt_id | input | 9 | Processor number of the event |
| rd_en | input | 1 | Byte read strobe |
| rd_addr | input | 5 | Byte offset of the read |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| wr_en | input | 1 | Byte write strobe (discarded) |
| wr_addr | input | 5 | Byte offset of the write (discarded) |
| wr_data | input | 8 | Write data (discarded) |
| gpe_set | output | 8 | One-cycle status-set request, bit 2 on each accepted event |
| evt_err | output | 1 | One-cycle pulse for an out-of-range event number |

## Verification
The hardest case to reach from the ports is a read and an event that land on the same byte in the same cycle. The read must return the old byte, and a read one cycle later must return the new one. The bench forces this on purpose by pairing reads and events on the byte in use, at both ends of the byte and on the first and last byte. It then runs a long mixed stretch in which reads, writes, events and out-of-range numbers overlap. A behavioural model of the map predicts `rd_data`, `gpe_set` and `evt_err` for every cycle.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;
   localparam int unsigned LANE_W = 8;

   typedef enum logic {
      HP_REMOVE = 1'b0,
      HP_ADD    = 1'b1
   } hp_kind_e;

   function automatic int unsigned lanes_for(input int unsigned slots);
      return slots / LANE_W;
   endfunction
endpackage

// File: rtl/cpuhp_evt_decode.sv
module cpuhp_evt_decode
   import cpuhp_pkg::*;
#(
   parameter int unsigned NUM_CPUS = 256,
   parameter int unsigned ID_W     = 9,
   localparam int unsigned IW      = $clog2(NUM_CPUS)
) (
   input  logic                evt_valid,
   input  hp_kind_e            evt_kind,
   input  logic [ID_W-1:0]     evt_id,
   output logic [NUM_CPUS-1:0] set_vec,
   output logic [NUM_CPUS-1:0] clr_vec,
   output logic                accept,
   output logic                reject
);
   localparam logic [ID_W:0] LIMIT = (ID_W+1)'(NUM_CPUS);

   logic                in_range;
   logic [NUM_CPUS-1:0] onehot;

   assign in_range = ({1'b0, evt_id} < LIMIT);
   assign accept   = evt_valid && in_range;
   assign reject   = evt_valid && !in_range;
   assign onehot   = NUM_CPUS'(1) << evt_id[IW-1:0];

   always_comb begin
      set_vec = '0;
      clr_vec = '0;
      if (accept) begin
         if (evt_kind == HP_ADD) set_vec = onehot;
         else                    clr_vec = onehot;
      end
   end
endmodule

// File: rtl/cpuhp_map_bank.sv
module cpuhp_map_bank
   import cpuhp_pkg::*;
#(
   parameter int unsigned NUM_CPUS = 256,
   localparam int unsigned NLANES  = lanes_for(NUM_CPUS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CPUS-1:0] boot_vec,
   input  logic [NUM_CPUS-1:0] set_vec,
   input  logic [NUM_CPUS-1:0] clr_vec,
   output logic [NUM_CPUS-1:0] map_q
);
   for (genvar b = 0; b < NLANES; b++) begin : g_lane
      logic [LANE_W-1:0] lane_q;
      always_ff @(posedge clk) begin
         if (!rst_n) lane_q <= boot_vec[b*LANE_W +: LANE_W];
         else        lane_q <= (lane_q & ~clr_vec[b*LANE_W +: LANE_W])
                               | set_vec[b*LANE_W +: LANE_W];
      end
      assign map_q[b*LANE_W +: LANE_W] = lane_q;
   end
endmodule

// File: rtl/cpuhp_rd_port.sv
module cpuhp_rd_port
   import cpuhp_pkg::*;
#(
   parameter int unsigned NUM_CPUS = 256,
   localparam int unsigned NLANES  = lanes_for(NUM_CPUS),
   localparam int unsigned AW      = (NLANES > 1) ? $clog2(NLANES) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_en,
   input  logic [AW-1:0]       rd_addr,
   input  logic [NUM_CPUS-1:0] map_q,
   output logic [LANE_W-1:0]   rd_data
);
   localparam logic [AW:0] LANE_LIM = (AW+1)'(NLANES);

   logic [LANE_W-1:0] lanes [2**AW];
   logic [LANE_W-1:0] pick;

   for (genvar b = 0; b < 2**AW; b++) begin : g_view
      if (b < NLANES) begin : g_real
         assign lanes[b] = map_q[b*LANE_W +: LANE_W];
      end else begin : g_hole
         assign lanes[b] = '0;
      end
   end

   assign pick = ({1'b0, rd_addr} < LANE_LIM) ? lanes[rd_addr] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= pick;
   end
endmodule

// File: rtl/cpuhp_notify.sv
module cpuhp_notify #(
   parameter int unsigned GPE_W   = 8,
   parameter int unsigned GPE_BIT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             reject,
   output logic [GPE_W-1:0] gpe_set,
   output logic             evt_err
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gpe_set <= '0;
         evt_err <= 1'b0;
      end else begin
         gpe_set <= accept ? (GPE_W'(1) << GPE_BIT) : '0;
         evt_err <= reject;
      end
   end
endmodule

// File: rtl/cpuhp_presence_map.sv
module cpuhp_presence_map
   import cpuhp_pkg::*;
#(
   parameter int unsigned NUM_CPUS = 256,
   parameter int unsigned ID_W     = 9,
   parameter int unsigned GPE_W    = 8,
   parameter int unsigned GPE_BIT  = 2,
   localparam int unsigned NLANES  = lanes_for(NUM_CPUS),
   localparam int unsigned AW      = (NLANES > 1) ? $clog2(NLANES) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CPUS-1:0] boot_present,
   input  logic                evt_valid,
   input  logic                evt_plug,
   input  logic [ID_W-1:0]     evt_id,
   input  logic                rd_en,
   input  logic [AW-1:0]       rd_addr,
   output logic [7:0]          rd_data,
   input  logic                wr_en,
   input  logic [AW-1:0]       wr_addr,
   input  logic [7:0]          wr_data,
   output logic [GPE_W-1:0]    gpe_set,
   output logic                evt_err
);
   if (NUM_CPUS % LANE_W != 0 || NUM_CPUS < 2*LANE_W) begin : g_bad_slots
      $error("NUM_CPUS must be a multiple of 8 and at least 16");
   end
   if ((NUM_CPUS - 1) >> ID_W != 0) begin : g_bad_id
      $error("ID_W too narrow for NUM_CPUS");
   end
   if (GPE_BIT >= GPE_W) begin : g_bad_gpe
      $error("GPE_BIT outside GPE_W");
   end

   logic [NUM_CPUS-1:0] set_vec;
   logic [NUM_CPUS-1:0] clr_vec;
   logic [NUM_CPUS-1:0] map_q;
   logic                accept;
   logic                reject;
   hp_kind_e            kind;

   // Window writes are taken from the bus and dropped (R6).
   logic unused_wr;
   assign unused_wr = ^{wr_en, wr_addr, wr_data};

   assign kind = evt_plug ? HP_ADD : HP_REMOVE;

   cpuhp_evt_decode #(.NUM_CPUS(NUM_CPUS), .ID_W(ID_W)) u_dec (
      .evt_valid (evt_valid),
      .evt_kind  (kind),
      .evt_id    (evt_id),
      .set_vec   (set_vec),
      .clr_vec   (clr_vec),
      .accept    (accept),
      .reject    (reject)
   );

   cpuhp_map_bank #(.NUM_CPUS(NUM_CPUS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .boot_vec (boot_present),
      .set_vec  (set_vec),
      .clr_vec  (clr_vec),
      .map_q    (map_q)
   );

   cpuhp_rd_port #(.NUM_CPUS(NUM_CPUS)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .map_q   (map_q),
      .rd_data (rd_data)
   );

   cpuhp_notify #(.GPE_W(GPE_W), .GPE_BIT(GPE_BIT)) u_ntf (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .reject  (reject),
      .gpe_set (gpe_set),
      .evt_err (evt_err)
   );
endmodule

// File: rtl/cpuhp_presence_map_chk.sv
module cpuhp_presence_map_chk #(
   parameter int unsigned NUM_CPUS = 256,
   parameter int unsigned ID_W     = 9,
   parameter int unsigned GPE_W    = 8,
   parameter int unsigned GPE_BIT  = 2,
   parameter int unsigned AW       = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                evt_valid,
   input logic                evt_plug,
   input logic [ID_W-1:0]     evt_id,
   input logic                rd_en,
   input logic [AW-1:0]       rd_addr,
   input logic [7:0]          rd_data,
   input logic [GPE_W-1:0]    gpe_set,
   input logic                evt_err,
   input logic [NUM_CPUS-1:0] map
);
   localparam int unsigned IW = $clog2(NUM_CPUS);
   localparam logic [ID_W:0] LIMIT = (ID_W+1)'(NUM_CPUS);
   localparam logic [AW:0] LANES = (AW+1)'(NUM_CPUS / 8);

   logic       ok_id;
   logic       ok_addr;
   logic [7:0] seen_byte;

   assign ok_id     = ({1'b0, evt_id} < LIMIT);
   assign ok_addr   = ({1'b0, rd_addr} < LANES);
   assign seen_byte = ok_addr ? map[{rd_addr, 3'b000} +: 8] : 8'h00;

   p_plug_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && ok_id && evt_plug) |=> map[$past(evt_id[IW-1:0])]);

   p_unplug_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && ok_id && !evt_plug) |=> !map[$past(evt_id[IW-1:0])]);

   p_gpe_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && ok_id) |=> (gpe_set == (GPE_W'(1) << GPE_BIT)));

   p_gpe_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt_valid && ok_id) |=> (gpe_set == '0));

   p_map_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid |=> $stable(map));

   p_bad_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && !ok_id) |=> (evt_err && $stable(map)));

   p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt_valid && !ok_id) |=> !evt_err);

   p_read_old_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> (rd_data == $past(seen_byte)));

   p_read_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
endmodule

bind cpuhp_presence_map cpuhp_presence_map_chk #(
   .NUM_CPUS (NUM_CPUS),
   .ID_W     (ID_W),
   .GPE_W    (GPE_W),
   .GPE_BIT  (GPE_BIT),
   .AW       (AW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_valid (evt_valid),
   .evt_plug  (evt_plug),
   .evt_id    (evt_id),
   .rd_en     (rd_en),
   .rd_addr   (rd_addr),
   .rd_data   (rd_data),
   .gpe_set   (gpe_set),
   .evt_err   (evt_err),
   .map       (map_q)
);

// File: tb/cpuhp_presence_map_test.sv
`timescale 1ns/1ps
module cpuhp_presence_map_test;
   logic         clk = 1'b0;
   logic         rst_n;
   logic [255:0] boot_present;
   logic         evt_valid, evt_plug;
   logic [8:0]   evt_id;
   logic         rd_en;
   logic [4:0]   rd_addr;
   logic [7:0]   rd_data;
   logic         wr_en;
   logic [4:0]   wr_addr;
   logic [7:0]   wr_data;
   logic [7:0]   gpe_set;
   logic         evt_err;

   always #5 clk = ~clk;

   cpuhp_presence_map uut (
      .clk(clk), .rst_n(rst_n), .boot_present(boot_present),
      .evt_valid(evt_valid), .evt_plug(evt_plug), .evt_id(evt_id),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .gpe_set(gpe_set), .evt_err(evt_err)
   );

   // behavioural reference
   bit   model [256];
   logic [7:0] e_rd, e_gpe;
   logic       e_err;
   int tests = 0, fails = 0;
   bit done = 0;
   string cur_req = "R1";

   function automatic logic [7:0] model_byte(input int k);
      logic [7:0] v;
      for (int j = 0; j < 8; j++) v[j] = model[k*8 + j];
      return v;
   endfunction

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) model[i] = boot_present[i];
         e_rd = 8'h00; e_gpe = 8'h00; e_err = 1'b0;
      end else begin
         if (rd_en) e_rd = model_byte(int'(rd_addr));
         e_gpe = 8'h00; e_err = 1'b0;
         if (evt_valid) begin
            if (evt_id < 9'd256) begin
               model[evt_id[7:0]] = evt_plug;
               e_gpe = 8'h04;
            end else e_err = 1'b1;
         end
      end
      @(posedge clk);
      @(negedge clk);
      check8(cur_req, rd_data, e_rd);
      check8("R5 gpe_set", gpe_set, e_gpe);
      check8("R7 evt_err", {7'b0, evt_err}, {7'b0, e_err});
   endtask

   task automatic idle();
      evt_valid = 0; evt_plug = 0; evt_id = '0;
      rd_en = 0; rd_addr = '0; wr_en = 0; wr_addr = '0; wr_data = '0;
   endtask

   task automatic do_read(input int k);
      idle(); rd_en = 1; rd_addr = 5'(k); tick();
   endtask

   task automatic read_all();
      for (int k = 0; k < 32; k++) do_read(k);
      idle(); tick();
   endtask

   task automatic do_evt(input bit plug, input int id);
      idle(); evt_valid = 1; evt_plug = plug; evt_id = 9'(id); tick();
   endtask

   task automatic evt_and_read(input bit plug, input int id);
      idle(); evt_valid = 1; evt_plug = plug; evt_id = 9'(id);
      rd_en = 1; rd_addr = 5'(id / 8); tick();     // old byte expected (R8)
      do_read(id / 8);                             // new byte expected (R8)
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog: got hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) boot_present[i] = ((i * 37 + 11) % 7) < 3;
      boot_present[0] = 1'b1; boot_present[255] = 1'b0;
      idle();
      rst_n = 0;
      cur_req = "R9";
      // reset outputs zero, even with activity on the inputs
      rd_en = 1; evt_valid = 1; evt_id = 9'd300;
      repeat (3) tick();
      idle(); rst_n = 1;
      tick();

      cur_req = "R1";  read_all();          // boot map visible (R1, R2)

      cur_req = "R3";
      do_evt(1, 255); do_evt(1, 8); do_evt(1, 0); do_evt(1, 130);
      read_all();
      cur_req = "R4";
      do_evt(0, 0); do_evt(0, 255); do_evt(0, 77);
      do_evt(0, 77);                        // clearing a clear bit
      read_all();

      cur_req = "R6";
      for (int k = 0; k < 64; k++) begin
         idle(); wr_en = 1; wr_addr = 5'(k); wr_data = 8'($urandom);
         tick();
      end
      read_all();

      cur_req = "R7";
      do_evt(1, 256); do_evt(0, 511); do_evt(1, 384);
      read_all();

      cur_req = "R8";
      evt_and_read(1, 7); evt_and_read(0, 7); evt_and_read(1, 248);
      evt_and_read(0, 0); evt_and_read(1, 255); evt_and_read(0, 255);

      cur_req = "R2";                       // hold when rd_en low
      do_read(3); idle(); repeat (4) tick();

      cur_req = "R3/R4 mixed";
      for (int n = 0; n < 3000; n++) begin
         idle();
         evt_valid = ($urandom % 3) != 0;
         evt_plug  = 1'($urandom);
         evt_id    = (($urandom % 10) == 0) ? 9'(256 + $urandom % 256) : 9'($urandom % 256);
         rd_en     = 1'($urandom);
         rd_addr   = (($urandom % 2) == 0) ? evt_id[7:3] : 5'($urandom);
         wr_en     = 1'($urandom);
         wr_addr   = 5'($urandom);
         wr_data   = 8'($urandom);
         tick();
      end
      cur_req = "R1 final"; read_all();

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule